// File: doc/BRIEF.md
# Serial Data Link Byte Collector

This block gathers the bits of a low-rate data link, as recovered by a T1 framer, into whole bytes for a host processor. Each link bit comes with a one-cycle strobe, roughly once every 250 microseconds. Bits are packed least-significant first, and every eighth strobe completes a byte. The byte is copied into a received-byte register. The framer outside this block decides which frame bit position feeds it, for example the extended-superframe link bit or the superframe Fs bit.

Each completed byte raises a sticky "byte ready" flag. The byte is also compared with a bank of programmable pattern bytes, two by default, and any hit raises a "pattern hit" flag. With this flag the host can ignore the link until a byte of interest arrives. If a byte completes while the previous one has not yet been acknowledged, the new byte replaces it and an "overrun" flag is raised. Each flag has its own interrupt enable. Together the enabled flags drive a single active-low interrupt line. The host reads and writes the registers through a simple single-cycle port and clears flags by writing ones to them.

Top module: `dl_byte_collector`

## Requirements
- R1: On each cycle where `dl_bit_valid` is high, `dl_bit` is shifted in. The first bit of a group of eight lands in bit 0 of the completed byte and the eighth in bit 7. Cycles without the strobe change neither the bit position nor the partial byte.
- R2: The received-byte register (address 0) holds the last completed byte and changes only when the next byte completes. A newer byte overwrites it whether or not the host has read it.
- R3: Every completed byte sets status bit 0 ("byte ready"). The flag is visible at address 1 by the second clock edge after the eighth strobe is sampled.
- R4: Status bit 1 ("pattern hit") is set when a completed byte equals pattern A (address 3) or pattern B (address 4). A byte that equals neither leaves it unchanged.
- R5: `irq_n` is low exactly when some status bit is set whose enable bit at address 2 is also set. The enable bits use the same bit positions as the status bits (0 ready, 1 hit, 2 overrun).
- R6: Writing address 1 clears the status bits that are written as 1 and leaves those written as 0 untouched. A status event in the same cycle as the clear wins, so the bit stays set.
- R7: Status bit 2 ("overrun") is set when a byte completes while "byte ready" is still set.
- R8: A synchronous reset (`rst` high at a clock edge) returns all of the following to zero: the bit position, the partial byte, the received byte, all status bits, the enables and the patterns. After reset `irq_n` is high.
- R9: Reads return the register selected by `host_addr` combinationally: 0 received byte, 1 status, 2 interrupt enables, 3 pattern A, 4 pattern B. Any other address reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dl_bit_valid | input | 1 | Strobe marking a valid link bit |
| dl_bit | input | 1 | Link bit value |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for `host_addr` |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach from the ports is a host clear that lands in the very cycle a status event is recorded. The clear must arrive one clock after the eighth strobe is sampled, when the completed byte is being committed. The bench brings this about by issuing the eighth strobe at one falling edge and placing the write-one-to-clear on the bus at the next falling edge, so that the same rising edge samples both. The other path the bench covers is a full sweep of all 256 byte values with uneven idle gaps between strobes. This checks the bit order, the two pattern comparators and the interrupt gating for every value.

// File: rtl/dl_byte_collector_pkg.sv
package dl_byte_collector_pkg;

    localparam int DL_ADDR_W   = 3;
    localparam int ST_W        = 3;
    localparam int ST_READY    = 0;
    localparam int ST_HIT      = 1;
    localparam int ST_OVERRUN  = 2;

    typedef enum logic [DL_ADDR_W-1:0] {
        A_RXBYTE  = 3'd0,
        A_STATUS  = 3'd1,
        A_IRQEN   = 3'd2,
        A_PATBASE = 3'd3
    } dl_addr_e;

    typedef struct packed {
        logic overrun;
        logic hit;
        logic ready;
    } dl_evt_t;

    function automatic logic [ST_W-1:0] evt_bits(input dl_evt_t e);
        return {e.overrun, e.hit, e.ready};
    endfunction

endpackage

// File: rtl/dl_bit_packer.sv
module dl_bit_packer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_valid,
    input  logic         bit_in,
    output logic         byte_done,
    output logic [W-1:0] byte_out
);
    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [W-1:0]     shift_q;
    logic [CNT_W-1:0] pos_q;
    logic [W-1:0]     shift_n;

    assign shift_n = {bit_in, shift_q[W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q   <= '0;
            pos_q     <= '0;
            byte_done <= 1'b0;
            byte_out  <= '0;
        end else begin
            byte_done <= 1'b0;
            if (bit_valid) begin
                shift_q <= shift_n;
                if (pos_q == LAST) begin
                    pos_q     <= '0;
                    byte_done <= 1'b1;
                    byte_out  <= shift_n;
                end else begin
                    pos_q <= pos_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dl_match_bank.sv
module dl_match_bank #(
    parameter int W = 8,
    parameter int N = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   wr_sel,
    input  logic [W-1:0]   wdata,
    input  logic [W-1:0]   byte_in,
    output logic           hit,
    output logic [N*W-1:0] patterns
);
    logic [N-1:0] eq;

    for (genvar i = 0; i < N; i++) begin : g_pat
        logic [W-1:0] pat_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                pat_q <= '0;
            end else if (wr_sel[i]) begin
                pat_q <= wdata;
            end
        end
        assign eq[i]              = (pat_q == byte_in);
        assign patterns[i*W +: W] = pat_q;
    end

    assign hit = |eq;
endmodule

// File: rtl/dl_status_regs.sv
module dl_status_regs
    import dl_byte_collector_pkg::*;
#(
    parameter int W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            byte_done,
    input  logic            pat_hit,
    input  logic [W-1:0]    byte_in,
    input  logic            clr_wr,
    input  logic [ST_W-1:0] clr_mask,
    input  logic            en_wr,
    input  logic [ST_W-1:0] en_data,
    output logic [ST_W-1:0] status,
    output logic [ST_W-1:0] irq_en,
    output logic [W-1:0]    rx_byte
);
    dl_evt_t         evt;
    logic [ST_W-1:0] clr;

    always_comb begin
        evt.ready   = byte_done;
        evt.hit     = byte_done & pat_hit;
        evt.overrun = byte_done & status[ST_READY];
        clr         = clr_wr ? clr_mask : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status  <= '0;
            irq_en  <= '0;
            rx_byte <= '0;
        end else begin
            status <= (status & ~clr) | evt_bits(evt);
            if (en_wr) begin
                irq_en <= en_data;
            end
            if (byte_done) begin
                rx_byte <= byte_in;
            end
        end
    end
endmodule

// File: rtl/dl_byte_collector.sv
module dl_byte_collector
    import dl_byte_collector_pkg::*;
#(
    parameter int W = 8,
    parameter int N_PAT = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dl_bit_valid,
    input  logic                 dl_bit,
    input  logic                 host_wr,
    input  logic [DL_ADDR_W-1:0] host_addr,
    input  logic [W-1:0]         host_wdata,
    output logic [W-1:0]         host_rdata,
    output logic                 irq_n
);
    localparam int PAT_BASE = int'(A_PATBASE);

    logic               byte_done;
    logic [W-1:0]       packed_byte;
    logic               pat_hit;
    logic [N_PAT*W-1:0] patterns;
    logic [N_PAT-1:0]   pat_wr;
    logic [ST_W-1:0]    status;
    logic [ST_W-1:0]    irq_en;
    logic [W-1:0]       rx_byte;

    dl_bit_packer #(.W(W)) packer_i (
        .clk(clk), .rst(rst),
        .bit_valid(dl_bit_valid), .bit_in(dl_bit),
        .byte_done(byte_done), .byte_out(packed_byte)
    );

    for (genvar i = 0; i < N_PAT; i++) begin : g_wsel
        assign pat_wr[i] = host_wr && (host_addr == DL_ADDR_W'(PAT_BASE + i));
    end

    dl_match_bank #(.W(W), .N(N_PAT)) match_i (
        .clk(clk), .rst(rst),
        .wr_sel(pat_wr), .wdata(host_wdata),
        .byte_in(packed_byte), .hit(pat_hit), .patterns(patterns)
    );

    dl_status_regs #(.W(W)) status_i (
        .clk(clk), .rst(rst),
        .byte_done(byte_done), .pat_hit(pat_hit), .byte_in(packed_byte),
        .clr_wr(host_wr && (host_addr == A_STATUS)),
        .clr_mask(host_wdata[ST_W-1:0]),
        .en_wr(host_wr && (host_addr == A_IRQEN)),
        .en_data(host_wdata[ST_W-1:0]),
        .status(status), .irq_en(irq_en), .rx_byte(rx_byte)
    );

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            A_RXBYTE: host_rdata = rx_byte;
            A_STATUS: host_rdata = {{(W-ST_W){1'b0}}, status};
            A_IRQEN:  host_rdata = {{(W-ST_W){1'b0}}, irq_en};
            default: begin
                for (int i = 0; i < N_PAT; i++) begin
                    if (host_addr == DL_ADDR_W'(PAT_BASE + i)) begin
                        host_rdata = patterns[i*W +: W];
                    end
                end
            end
        endcase
    end

    assign irq_n = ~|(status & irq_en);
endmodule

// File: rtl/dl_byte_collector_chk.sv
module dl_byte_collector_chk
    import dl_byte_collector_pkg::*;
#(
    parameter int W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            dl_bit_valid,
    input logic            byte_done,
    input logic [ST_W-1:0] status,
    input logic [ST_W-1:0] irq_en,
    input logic [W-1:0]    rx_byte,
    input logic            host_wr,
    input logic [DL_ADDR_W-1:0] host_addr,
    input logic            irq_n
);
    AST_DONE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        byte_done |-> $past(dl_bit_valid)); // R1
    AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !byte_done |=> $stable(rx_byte)); // R2
    AST_READY_SET: assert property (@(posedge clk) disable iff (rst)
        byte_done |=> status[ST_READY]); // R3
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (status != '0)); // R5
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (irq_en == '0) |-> irq_n); // R5
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!byte_done && !(host_wr && host_addr == A_STATUS)) |=> $stable(status)); // R6
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
        (byte_done && status[ST_READY]) |=> status[ST_OVERRUN]); // R7
endmodule

bind dl_byte_collector dl_byte_collector_chk #(.W(W)) chk_i (
    .clk(clk), .rst(rst), .dl_bit_valid(dl_bit_valid),
    .byte_done(byte_done), .status(status), .irq_en(irq_en),
    .rx_byte(rx_byte), .host_wr(host_wr), .host_addr(host_addr),
    .irq_n(irq_n)
);

// File: tb/dl_byte_collector_tb_top.sv
module dl_byte_collector_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dl_bit_valid = 1'b0;
    logic       dl_bit = 1'b0;
    logic       host_wr = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [7:0] rd;

    localparam logic [7:0] PAT_A = 8'h5A;
    localparam logic [7:0] PAT_B = 8'hC3;

    always #4 clk = ~clk;

    dl_byte_collector dut_i (
        .clk(clk), .rst(rst), .dl_bit_valid(dl_bit_valid), .dl_bit(dl_bit),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic send_bit(input logic b, input int gap);
        @(negedge clk);
        dl_bit_valid = 1'b1; dl_bit = b;
        @(negedge clk);
        dl_bit_valid = 1'b0; dl_bit = ~b;
        repeat (gap) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v, input int gap);
        for (int i = 0; i < 8; i++) send_bit(v[i], (gap + i) % 3);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                finish_run();
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R8, R9: everything reads zero after reset
        for (int a = 0; a < 8; a++) begin
            rd_reg(3'(a), rd);
            chk("R8 reset value", rd, 8'h00);
        end
        chk("R8 irq_n after reset", {7'd0, irq_n}, 8'h01);

        wr_reg(3, PAT_A);
        wr_reg(4, PAT_B);
        wr_reg(2, 8'h02);
        rd_reg(3, rd); chk("R9 pattern A", rd, PAT_A);
        rd_reg(4, rd); chk("R9 pattern B", rd, PAT_B);
        rd_reg(2, rd); chk("R9 enables", rd, 8'h02);
        rd_reg(7, rd); chk("R9 unmapped", rd, 8'h00);

        // R1, R3, R4, R5: sweep every byte value with uneven gaps
        for (int v = 0; v < 256; v++) begin
            logic hitv;
            hitv = (8'(v) == PAT_A) || (8'(v) == PAT_B);
            wr_reg(1, 8'h07);
            send_byte(8'(v), v % 3);
            rd_reg(0, rd); chk("R1 packed byte", rd, 8'(v));
            rd_reg(1, rd); chk("R3 R4 status", rd, {6'd0, hitv, 1'b1});
            chk("R5 irq on hit only", {7'd0, irq_n}, {7'd0, ~hitv});
        end

        // R7, R2: new byte while ready still set
        send_byte(8'h11, 1);
        rd_reg(0, rd); chk("R2 overwrite", rd, 8'h11);
        rd_reg(1, rd); chk("R7 overrun", rd, 8'h05);
        chk("R5 irq masked", {7'd0, irq_n}, 8'h01);
        wr_reg(2, 8'h04);
        chk("R5 overrun enable", {7'd0, irq_n}, 8'h00);
        wr_reg(2, 8'h00);
        chk("R5 all disabled", {7'd0, irq_n}, 8'h01);

        // R6: partial clear and zero write
        wr_reg(1, 8'h01);
        rd_reg(1, rd); chk("R6 clear ready only", rd, 8'h04);
        wr_reg(1, 8'h00);
        rd_reg(1, rd); chk("R6 zero write", rd, 8'h04);
        wr_reg(1, 8'h07);
        rd_reg(1, rd); chk("R6 clear all", rd, 8'h00);

        // R6: clear in the same cycle as the ready event
        for (int i = 0; i < 7; i++) send_bit(1'b0, 0);
        @(negedge clk);
        dl_bit_valid = 1'b1; dl_bit = 1'b1;
        @(negedge clk);
        dl_bit_valid = 1'b0;
        host_wr = 1'b1; host_addr = 3'd1; host_wdata = 8'h01;
        @(negedge clk);
        host_wr = 1'b0;
        rd_reg(1, rd); chk("R6 set beats clear", rd, 8'h01);
        rd_reg(0, rd); chk("R1 last bit msb", rd, 8'h80);

        // R8: reset mid-byte restarts the bit position
        for (int i = 0; i < 3; i++) send_bit(1'b1, 0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd_reg(1, rd); chk("R8 status cleared", rd, 8'h00);
        rd_reg(3, rd); chk("R8 pattern cleared", rd, 8'h00);
        send_byte(8'hA5, 0);
        rd_reg(0, rd); chk("R8 position restart", rd, 8'hA5);
        rd_reg(1, rd); chk("R4 no hit", rd, 8'h01);

        finish_run();
    end
endmodule